// File: doc/BRIEF.md
# Receive Reset Sequencer for a Serial Transceiver

This block brings the receive side of a high-speed serial transceiver out of reset in a fixed order. It runs on a free-running stable clock, drives the PLL reset, the receiver reset and the receiver user-ready line, and watches the PLL lock, transmit user-ready, receiver reset-done, phase-alignment-done and data-valid status lines. Every status line crosses into the stable clock domain through a two-flop synchronizer before the sequencer looks at it. The recovered-clock stability flag is produced inside the block by a settling counter that starts when the receiver reset is released.

The order is: PLL and receiver reset held together, PLL reset released while waiting for lock, receiver reset released, a wait for recovered-clock stability (and, when the receive user clock comes from the transmit side, for transmit user-ready), user-ready asserted, a wait for reset-done, an optional phase-alignment handshake when the elastic buffer is bypassed, a data-valid qualification window, a short settle time and finally the done flag. Any early step that stalls past a timeout restarts the whole order and bumps a saturating retry count. All windows are given in nanoseconds and converted to stable-clock cycles from the clock period parameter.

Top module: `rxrst_seq`

## Requirements
- R1: After reset or a retry, pll_rst_o and rx_rst_o are both high for RST_HOLD_CYC cycles; then pll_rst_o drops while rx_rst_o stays high until synchronized PLL lock is seen, and pll_rst_o is never high without rx_rst_o.
- R2: rx_rst_o falls on the edge that follows a cycle with synchronized lock high; the internal clock-stable flag sets after CDR_WAIT cycles of rx_rst_o low and clears on the edge after any cycle with rx_rst_o high. Every window in cycles is ceil(window_ns / CLK_PERIOD_NS).
- R3: rx_urdy_o rises only after a cycle in which clock-stable is high and, when USRCLK_FROM_TX is 1, synchronized transmit user-ready is high (with USRCLK_FROM_TX 0 that term is always met); it then stays high until the sequence restarts.
- R4: With rx_urdy_o high the sequencer waits for synchronized reset-done and advances on it; no later step starts before it.
- R5: When RX_BUF_BYPASS is 1, pha_run_o is a single-cycle pulse on entry to the alignment step and the sequencer waits for synchronized alignment-done; when RX_BUF_BYPASS is 0 the step is skipped and pha_run_o never goes high.
- R6: Synchronized data-valid must be high for VALID_WIN cycles in a row, then stay high for SETTLE more cycles, before rst_done_o rises; any low cycle restarts the window from zero.
- R7: If synchronized data-valid is low while rst_done_o is high, rst_done_o clears on the next edge and the data-valid window starts again.
- R8: If lock, clock-stable (with transmit ready), reset-done or alignment-done is not seen within TIMEOUT cycles of entering its step, the sequencer returns to the R1 reset step and retry_o increases by one, saturating at 2^RETRY_W-1.
- R9: Each status input is seen by the sequencer two clock edges after it is sampled at the block edge.
- R10: While rst is high: pll_rst_o=1, rx_rst_o=1, rx_urdy_o=0, pha_run_o=0, rst_done_o=0, retry_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running stable clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| pll_lock_i | input | 1 | PLL lock status, asynchronous |
| tx_urdy_i | input | 1 | Transmit user-ready status, asynchronous |
| rx_rdone_i | input | 1 | Receiver reset-done status, asynchronous |
| pha_done_i | input | 1 | Phase-alignment-done status, asynchronous |
| data_valid_i | input | 1 | Received data valid, asynchronous |
| pll_rst_o | output | 1 | PLL reset |
| rx_rst_o | output | 1 | Receiver reset |
| rx_urdy_o | output | 1 | Receiver user-ready |
| pha_run_o | output | 1 | Single-cycle request to run phase alignment |
| rst_done_o | output | 1 | Receive bring-up complete |
| retry_o | output | RETRY_W | Saturating count of timeout restarts |

## Verification
The bench builds two instances side by side on shared stimulus: one with the buffer bypassed, the user clock taken from the transmit side and a 2-bit retry count, and one with the buffer in use, an independent user clock and an 8-bit retry count. The windows are shrunk to 100 ns of clock settling, 500 ns of timeout, 200 ns of data-valid qualification and 50 ns of settle at a 5 ns period, so timeouts, retry saturation after three restarts, window restarts and the data-valid drop after done all happen within a few thousand cycles. The pairing makes the alignment pulse and the transmit-ready gate visible in one instance while the other shows both being absent.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

   typedef enum logic [2:0] {
      ST_RESET  = 3'd0,
      ST_LOCK   = 3'd1,
      ST_CLK    = 3'd2,
      ST_RDONE  = 3'd3,
      ST_PHA    = 3'd4,
      ST_VALID  = 3'd5,
      ST_SETTLE = 3'd6,
      ST_DONE   = 3'd7
   } rxrst_state_e;

   // status input lane positions in the synchronizer vector
   localparam int LN_VALID = 0;
   localparam int LN_PHA   = 1;
   localparam int LN_RDONE = 2;
   localparam int LN_TXRDY = 3;
   localparam int LN_LOCK  = 4;
   localparam int LN_COUNT = 5;

   function automatic int ns_to_cyc(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   if (W < 1) begin : g_bad_w
      $error("rxrst_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("rxrst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rxrst_cdr_wait.sv
module rxrst_cdr_wait #(
   parameter int WAIT_CYC = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic rx_rst,
   output logic stable_o
);

   localparam int CNT_W = $clog2(WAIT_CYC + 1);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("rxrst_cdr_wait: WAIT_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             stable_q;

   always_ff @(posedge clk) begin
      if (rst || rx_rst) begin
         cnt_q    <= '0;
         stable_q <= 1'b0;
      end else if (!stable_q) begin
         if (cnt_q == CNT_W'(WAIT_CYC - 1)) begin
            stable_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign stable_o = stable_q;

endmodule

// File: rtl/rxrst_sat_cnt.sv
module rxrst_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != TOP)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
   import rxrst_pkg::*;
#(
   parameter int CLK_PERIOD_NS  = 5,
   parameter int RETRY_W        = 8,
   parameter bit RX_BUF_BYPASS  = 1'b1,
   parameter bit USRCLK_FROM_TX = 1'b0,
   parameter int RST_HOLD_CYC   = 4,
   parameter int CDR_WAIT_NS    = 20000,
   parameter int TIMEOUT_NS     = 500000,
   parameter int VALID_WIN_NS   = 100000,
   parameter int SETTLE_NS      = 1000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pll_lock_i,
   input  logic               tx_urdy_i,
   input  logic               rx_rdone_i,
   input  logic               pha_done_i,
   input  logic               data_valid_i,
   output logic               pll_rst_o,
   output logic               rx_rst_o,
   output logic               rx_urdy_o,
   output logic               pha_run_o,
   output logic               rst_done_o,
   output logic [RETRY_W-1:0] retry_o
);

   // ------------------------------------------------------------------
   // Derived cycle counts
   // ------------------------------------------------------------------
   localparam int CDR_CYC    = ns_to_cyc(CDR_WAIT_NS, CLK_PERIOD_NS);
   localparam int TMO_CYC    = ns_to_cyc(TIMEOUT_NS, CLK_PERIOD_NS);
   localparam int VALID_CYC  = ns_to_cyc(VALID_WIN_NS, CLK_PERIOD_NS);
   localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PERIOD_NS);
   localparam int TMR_MAX    = max4(TMO_CYC, VALID_CYC, SETTLE_CYC, RST_HOLD_CYC);
   localparam int TMR_W      = $clog2(TMR_MAX + 1);

   localparam rxrst_state_e POST_RDONE = RX_BUF_BYPASS ? ST_PHA : ST_VALID;

   // ------------------------------------------------------------------
   // Elaboration checks
   // ------------------------------------------------------------------
   if (CLK_PERIOD_NS < 4 || CLK_PERIOD_NS > 20) begin : g_bad_period
      $error("rxrst_seq: CLK_PERIOD_NS must lie in 4..20");
   end
   if (RETRY_W < 2 || RETRY_W > 8) begin : g_bad_retry_w
      $error("rxrst_seq: RETRY_W must lie in 2..8");
   end
   if (RST_HOLD_CYC < 1) begin : g_bad_hold
      $error("rxrst_seq: RST_HOLD_CYC must be at least 1");
   end
   if (TMO_CYC <= CDR_CYC) begin : g_bad_timeout
      $error("rxrst_seq: timeout must exceed the clock settling wait");
   end

   // ------------------------------------------------------------------
   // Input synchronization
   // ------------------------------------------------------------------
   logic [LN_COUNT-1:0] stat_async;
   logic [LN_COUNT-1:0] stat_sync;

   always_comb begin
      stat_async           = '0;
      stat_async[LN_LOCK]  = pll_lock_i;
      stat_async[LN_TXRDY] = tx_urdy_i;
      stat_async[LN_RDONE] = rx_rdone_i;
      stat_async[LN_PHA]   = pha_done_i;
      stat_async[LN_VALID] = data_valid_i;
   end

   rxrst_sync #(
      .W      (LN_COUNT),
      .STAGES (2)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (stat_async),
      .sync_o  (stat_sync)
   );

   logic lock_s, txrdy_s, rdone_s, pha_s, valid_s;
   assign lock_s  = stat_sync[LN_LOCK];
   assign txrdy_s = stat_sync[LN_TXRDY];
   assign rdone_s = stat_sync[LN_RDONE];
   assign pha_s   = stat_sync[LN_PHA];
   assign valid_s = stat_sync[LN_VALID];

   // transmit-ready gate: only meaningful when the receive user clock
   // is taken from the transmit side
   logic tx_ok;
   if (USRCLK_FROM_TX) begin : g_tx_gate
      assign tx_ok = txrdy_s;
   end else begin : g_no_tx_gate
      assign tx_ok = 1'b1;
   end

   // ------------------------------------------------------------------
   // Recovered clock settling
   // ------------------------------------------------------------------
   logic clk_stable;

   rxrst_cdr_wait #(
      .WAIT_CYC (CDR_CYC)
   ) u_cdr (
      .clk      (clk),
      .rst      (rst),
      .rx_rst   (rx_rst_o),
      .stable_o (clk_stable)
   );

   // ------------------------------------------------------------------
   // Sequencer
   // ------------------------------------------------------------------
   rxrst_state_e     st_q, st_d;
   logic [TMR_W-1:0] tmr_q, tmr_d;
   logic             retry_inc;
   logic             tmo_hit;

   assign tmo_hit = (tmr_q == TMR_W'(TMO_CYC - 1));

   always_comb begin
      st_d      = st_q;
      tmr_d     = tmr_q + 1'b1;
      retry_inc = 1'b0;
      case (st_q)
         ST_RESET: begin
            if (tmr_q == TMR_W'(RST_HOLD_CYC - 1)) begin
               st_d  = ST_LOCK;
               tmr_d = '0;
            end
         end
         ST_LOCK: begin
            if (lock_s) begin
               st_d  = ST_CLK;
               tmr_d = '0;
            end else if (tmo_hit) begin
               st_d      = ST_RESET;
               tmr_d     = '0;
               retry_inc = 1'b1;
            end
         end
         ST_CLK: begin
            if (clk_stable && tx_ok) begin
               st_d  = ST_RDONE;
               tmr_d = '0;
            end else if (tmo_hit) begin
               st_d      = ST_RESET;
               tmr_d     = '0;
               retry_inc = 1'b1;
            end
         end
         ST_RDONE: begin
            if (rdone_s) begin
               st_d  = POST_RDONE;
               tmr_d = '0;
            end else if (tmo_hit) begin
               st_d      = ST_RESET;
               tmr_d     = '0;
               retry_inc = 1'b1;
            end
         end
         ST_PHA: begin
            if (pha_s) begin
               st_d  = ST_VALID;
               tmr_d = '0;
            end else if (tmo_hit) begin
               st_d      = ST_RESET;
               tmr_d     = '0;
               retry_inc = 1'b1;
            end
         end
         ST_VALID: begin
            if (!valid_s) begin
               tmr_d = '0;
            end else if (tmr_q == TMR_W'(VALID_CYC - 1)) begin
               st_d  = ST_SETTLE;
               tmr_d = '0;
            end
         end
         ST_SETTLE: begin
            if (!valid_s) begin
               st_d  = ST_VALID;
               tmr_d = '0;
            end else if (tmr_q == TMR_W'(SETTLE_CYC - 1)) begin
               st_d  = ST_DONE;
               tmr_d = '0;
            end
         end
         ST_DONE: begin
            tmr_d = tmr_q;
            if (!valid_s) begin
               st_d  = ST_VALID;
               tmr_d = '0;
            end
         end
         default: begin
            st_d  = ST_RESET;
            tmr_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_RESET;
         tmr_q <= '0;
      end else begin
         st_q  <= st_d;
         tmr_q <= tmr_d;
      end
   end

   rxrst_sat_cnt #(
      .W (RETRY_W)
   ) u_retry (
      .clk   (clk),
      .rst   (rst),
      .inc   (retry_inc),
      .cnt_o (retry_o)
   );

   // ------------------------------------------------------------------
   // Outputs decoded from the registered state
   // ------------------------------------------------------------------
   assign pll_rst_o  = (st_q == ST_RESET);
   assign rx_rst_o   = (st_q == ST_RESET) || (st_q == ST_LOCK);
   assign rx_urdy_o  = (st_q == ST_RDONE) || (st_q == ST_PHA) || (st_q == ST_VALID) ||
                       (st_q == ST_SETTLE) || (st_q == ST_DONE);
   assign pha_run_o  = (st_q == ST_PHA) && (tmr_q == '0);
   assign rst_done_o = (st_q == ST_DONE);

endmodule

// File: rtl/rxrst_seq_chk.sv
module rxrst_seq_chk #(
   parameter int RETRY_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               pll_rst,
   input logic               rx_rst,
   input logic               rx_urdy,
   input logic               pha_run,
   input logic               rst_done,
   input logic [RETRY_W-1:0] retry,
   input logic               lock_s,
   input logic               clk_stable,
   input logic               tx_ok,
   input logic               valid_s
);

   localparam logic [RETRY_W-1:0] RMAX = '1;

   // R1: the PLL is never held in reset with the receiver released
   p_pll_in_rx_r1: assert property (@(posedge clk) disable iff (rst)
      pll_rst |-> rx_rst);

   // R2: receiver reset is released only after a cycle with lock seen
   p_rx_release_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_rst) |-> $past(lock_s));

   // R2: clock-stable is cleared after any cycle with receiver reset high
   p_stable_clear_r2: assert property (@(posedge clk) disable iff (rst)
      rx_rst |=> !clk_stable);

   // R3: user-ready rises only after clock-stable and transmit gate
   p_urdy_gate_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_urdy) |-> $past(clk_stable && tx_ok));

   // R5: alignment request is a single-cycle pulse
   p_run_single_r5: assert property (@(posedge clk) disable iff (rst)
      pha_run |=> !pha_run);

   // R6: done implies the receiver is out of reset and user-ready
   p_done_urdy_r6: assert property (@(posedge clk) disable iff (rst)
      rst_done |-> (rx_urdy && !rx_rst));

   // R6: done rises only while data-valid is seen
   p_done_rise_valid_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(rst_done) |-> $past(valid_s));

   // R7: data-valid loss clears done on the next edge
   p_done_drop_r7: assert property (@(posedge clk) disable iff (rst)
      (rst_done && !valid_s) |=> !rst_done);

   // R8: retry count moves only by single increments
   p_retry_step_r8: assert property (@(posedge clk) disable iff (rst)
      (retry != $past(retry)) |-> (retry == $past(retry) + 1'b1));

   // R8: retry count holds once saturated
   p_retry_sat_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(retry) == RMAX) |-> (retry == RMAX));

endmodule

bind rxrst_seq rxrst_seq_chk #(
   .RETRY_W (RETRY_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .pll_rst    (pll_rst_o),
   .rx_rst     (rx_rst_o),
   .rx_urdy    (rx_urdy_o),
   .pha_run    (pha_run_o),
   .rst_done   (rst_done_o),
   .retry      (retry_o),
   .lock_s     (lock_s),
   .clk_stable (clk_stable),
   .tx_ok      (tx_ok),
   .valid_s    (valid_s)
);

// File: tb/rxrst_ref_model.sv
module rxrst_ref_model #(
   parameter int HOLD    = 3,
   parameter int CDR     = 20,
   parameter int TMO     = 100,
   parameter int VWIN    = 40,
   parameter int SETTLE  = 10,
   parameter int RMAX    = 3,
   parameter bit BYP     = 1'b1,
   parameter bit FROM_TX = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic lock,
   input  logic txrdy,
   input  logic rdone,
   input  logic phadone,
   input  logic valid,
   output logic x_pll_rst,
   output logic x_rx_rst,
   output logic x_urdy,
   output logic x_run,
   output logic x_done,
   output int   x_retry
);

   // step numbers: 0 reset hold, 1 lock wait, 2 clock wait, 3 reset-done
   // wait, 4 alignment, 5 valid window, 6 settle, 7 done
   int       step;
   int       waited;
   int       retries;
   int       settle_cnt;
   bit       stable;
   bit [4:0] seen_prev, seen_now;

   function automatic bit in_rx_reset(input int s);
      return (s == 0) || (s == 1);
   endfunction

   always @(posedge clk) begin
      bit [4:0] used;
      bit       was_rx_rst;
      bit       stable_used;
      bit       fail;
      if (rst) begin
         step       = 0;
         waited     = 0;
         retries    = 0;
         settle_cnt = 0;
         stable     = 1'b0;
         seen_prev  = '0;
         seen_now   = '0;
      end else begin
         // two-edge delay of the status lines: {lock,txrdy,rdone,pha,valid}
         used       = seen_now;
         seen_now   = seen_prev;
         seen_prev  = {lock, txrdy, rdone, phadone, valid};
         was_rx_rst = in_rx_reset(step);
         stable_used = stable;
         if (was_rx_rst) begin
            settle_cnt = 0;
            stable     = 1'b0;
         end else if (!stable) begin
            if (settle_cnt == CDR - 1) stable = 1'b1;
            else settle_cnt++;
         end
         fail = 1'b0;
         case (step)
            0: begin
               if (waited == HOLD - 1) begin step = 1; waited = 0; end
               else waited++;
            end
            1: begin
               if (used[4]) begin step = 2; waited = 0; end
               else if (waited == TMO - 1) fail = 1'b1;
               else waited++;
            end
            2: begin
               if (stable_used && (used[3] || !FROM_TX)) begin step = 3; waited = 0; end
               else if (waited == TMO - 1) fail = 1'b1;
               else waited++;
            end
            3: begin
               if (used[2]) begin step = BYP ? 4 : 5; waited = 0; end
               else if (waited == TMO - 1) fail = 1'b1;
               else waited++;
            end
            4: begin
               if (used[1]) begin step = 5; waited = 0; end
               else if (waited == TMO - 1) fail = 1'b1;
               else waited++;
            end
            5: begin
               if (!used[0]) waited = 0;
               else if (waited == VWIN - 1) begin step = 6; waited = 0; end
               else waited++;
            end
            6: begin
               if (!used[0]) begin step = 5; waited = 0; end
               else if (waited == SETTLE - 1) begin step = 7; waited = 0; end
               else waited++;
            end
            default: begin
               if (!used[0]) begin step = 5; waited = 0; end
            end
         endcase
         if (fail) begin
            step   = 0;
            waited = 0;
            if (retries < RMAX) retries++;
         end
      end
   end

   assign x_pll_rst = (step == 0);
   assign x_rx_rst  = in_rx_reset(step);
   assign x_urdy    = (step >= 3);
   assign x_run     = (step == 4) && (waited == 0);
   assign x_done    = (step == 7);
   assign x_retry   = retries;

endmodule

// File: tb/rxrst_seq_tb_top.sv
`timescale 1ns/1ps
module rxrst_seq_tb_top;

   localparam int PER_NS    = 5;
   localparam int HOLD_CYC  = 3;
   localparam int CDR_NS    = 100;
   localparam int TMO_NS    = 500;
   localparam int VWIN_NS   = 200;
   localparam int SETTLE_NS = 50;
   localparam int CDR_C     = (CDR_NS + PER_NS - 1) / PER_NS;
   localparam int TMO_C     = (TMO_NS + PER_NS - 1) / PER_NS;
   localparam int VWIN_C    = (VWIN_NS + PER_NS - 1) / PER_NS;
   localparam int SETTLE_C  = (SETTLE_NS + PER_NS - 1) / PER_NS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic lock = 1'b0, txrdy = 1'b0, rdone = 1'b0, phadone = 1'b0, valid = 1'b0;

   always #2.5 clk = ~clk;

   // instance A: buffer bypassed, user clock from transmit side, 2-bit retry
   logic       a_pll, a_rx, a_urdy, a_run, a_done;
   logic [1:0] a_retry;
   rxrst_seq #(
      .CLK_PERIOD_NS (PER_NS), .RETRY_W (2), .RX_BUF_BYPASS (1'b1),
      .USRCLK_FROM_TX (1'b1), .RST_HOLD_CYC (HOLD_CYC), .CDR_WAIT_NS (CDR_NS),
      .TIMEOUT_NS (TMO_NS), .VALID_WIN_NS (VWIN_NS), .SETTLE_NS (SETTLE_NS)
   ) dut_i (
      .clk (clk), .rst (rst), .pll_lock_i (lock), .tx_urdy_i (txrdy),
      .rx_rdone_i (rdone), .pha_done_i (phadone), .data_valid_i (valid),
      .pll_rst_o (a_pll), .rx_rst_o (a_rx), .rx_urdy_o (a_urdy),
      .pha_run_o (a_run), .rst_done_o (a_done), .retry_o (a_retry)
   );

   // instance B: buffer in use, independent user clock, 8-bit retry
   logic       b_pll, b_rx, b_urdy, b_run, b_done;
   logic [7:0] b_retry;
   rxrst_seq #(
      .CLK_PERIOD_NS (PER_NS), .RETRY_W (8), .RX_BUF_BYPASS (1'b0),
      .USRCLK_FROM_TX (1'b0), .RST_HOLD_CYC (HOLD_CYC), .CDR_WAIT_NS (CDR_NS),
      .TIMEOUT_NS (TMO_NS), .VALID_WIN_NS (VWIN_NS), .SETTLE_NS (SETTLE_NS)
   ) dut_buf_i (
      .clk (clk), .rst (rst), .pll_lock_i (lock), .tx_urdy_i (txrdy),
      .rx_rdone_i (rdone), .pha_done_i (phadone), .data_valid_i (valid),
      .pll_rst_o (b_pll), .rx_rst_o (b_rx), .rx_urdy_o (b_urdy),
      .pha_run_o (b_run), .rst_done_o (b_done), .retry_o (b_retry)
   );

   logic ea_pll, ea_rx, ea_urdy, ea_run, ea_done;
   int   ea_retry;
   rxrst_ref_model #(
      .HOLD (HOLD_CYC), .CDR (CDR_C), .TMO (TMO_C), .VWIN (VWIN_C), .SETTLE (SETTLE_C),
      .RMAX (3), .BYP (1'b1), .FROM_TX (1'b1)
   ) ref_a (
      .clk (clk), .rst (rst), .lock (lock), .txrdy (txrdy), .rdone (rdone),
      .phadone (phadone), .valid (valid), .x_pll_rst (ea_pll), .x_rx_rst (ea_rx),
      .x_urdy (ea_urdy), .x_run (ea_run), .x_done (ea_done), .x_retry (ea_retry)
   );

   logic eb_pll, eb_rx, eb_urdy, eb_run, eb_done;
   int   eb_retry;
   rxrst_ref_model #(
      .HOLD (HOLD_CYC), .CDR (CDR_C), .TMO (TMO_C), .VWIN (VWIN_C), .SETTLE (SETTLE_C),
      .RMAX (255), .BYP (1'b0), .FROM_TX (1'b0)
   ) ref_b (
      .clk (clk), .rst (rst), .lock (lock), .txrdy (txrdy), .rdone (rdone),
      .phadone (phadone), .valid (valid), .x_pll_rst (eb_pll), .x_rx_rst (eb_rx),
      .x_urdy (eb_urdy), .x_run (eb_run), .x_done (eb_done), .x_retry (eb_retry)
   );

   int n_vec  = 0;
   int n_fail = 0;
   int a_pulses = 0;
   int b_pulses = 0;
   bit started  = 1'b0;
   bit finished = 1'b0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) started <= 1'b1;

   // Per-cycle comparison against the reference models. The models delay
   // every status line by two edges, so each compare also covers R9; the
   // user-ready compare covers R3 and R4 together.
   always @(negedge clk) begin
      if (started && !finished) begin
         check("R1", "A pll_rst", int'(a_pll), int'(ea_pll));
         check("R2", "A rx_rst", int'(a_rx), int'(ea_rx));
         check("R3", "A rx_urdy", int'(a_urdy), int'(ea_urdy));
         check("R5", "A pha_run", int'(a_run), int'(ea_run));
         check("R6", "A rst_done", int'(a_done), int'(ea_done));
         check("R8", "A retry", int'(a_retry), ea_retry);
         check("R1", "B pll_rst", int'(b_pll), int'(eb_pll));
         check("R2", "B rx_rst", int'(b_rx), int'(eb_rx));
         check("R4", "B rx_urdy", int'(b_urdy), int'(eb_urdy));
         check("R5", "B pha_run", int'(b_run), int'(eb_run));
         check("R7", "B rst_done", int'(b_done), int'(eb_done));
         check("R8", "B retry", int'(b_retry), eb_retry);
         if (a_run) a_pulses++;
         if (b_run) b_pulses++;
      end
   end

   initial begin
      wait_n(5);
      // R10: reset values
      check("R10", "A pll_rst in reset", int'(a_pll), 1);
      check("R10", "A rx_rst in reset", int'(a_rx), 1);
      check("R10", "A urdy in reset", int'(a_urdy), 0);
      check("R10", "A done in reset", int'(a_done), 0);
      check("R10", "B retry in reset", int'(b_retry), 0);
      check("R10", "B run in reset", int'(b_run), 0);
      rst = 1'b0;

      // normal bring-up; A is held back by transmit ready (R3)
      wait_n(10);
      lock = 1'b1;
      wait_n(40);
      check("R3", "A urdy before tx ready", int'(a_urdy), 0);
      check("R3", "B urdy without tx gate", int'(b_urdy), 1);
      txrdy = 1'b1;
      wait_n(10);
      rdone = 1'b1;
      valid = 1'b1;
      wait_n(20);
      phadone = 1'b1;
      wait_n(130);
      check("R6", "A done after window", int'(a_done), 1);
      check("R6", "B done after window", int'(b_done), 1);

      // R7: data-valid loss after done
      valid = 1'b0;
      wait_n(4);
      check("R7", "A done after valid loss", int'(a_done), 0);
      check("R7", "B done after valid loss", int'(b_done), 0);
      wait_n(1);
      valid = 1'b1;
      wait_n(20);
      // R6: one low cycle inside the window restarts it
      valid = 1'b0;
      wait_n(1);
      valid = 1'b1;
      wait_n(45);
      check("R6", "A done before restarted window ends", int'(a_done), 0);
      check("R6", "B done before restarted window ends", int'(b_done), 0);
      wait_n(30);
      check("R6", "A done after restarted window", int'(a_done), 1);
      check("R6", "B done after restarted window", int'(b_done), 1);

      // R8: repeated lock timeouts
      rst = 1'b1;
      lock = 1'b0; txrdy = 1'b0; rdone = 1'b0; phadone = 1'b0; valid = 1'b0;
      wait_n(5);
      rst = 1'b0;
      wait_n(450);
      check("R8", "A retry saturated", int'(a_retry), 3);
      check("R8", "B retry after four timeouts", int'(b_retry), 4);
      lock = 1'b1;
      wait_n(40);
      // R4: B is user-ready and parked on reset-done
      check("R4", "B urdy waiting reset-done", int'(b_urdy), 1);
      check("R4", "B done while reset-done low", int'(b_done), 0);
      wait_n(160);
      txrdy = 1'b1; rdone = 1'b1; phadone = 1'b1; valid = 1'b1;
      wait_n(250);
      check("R6", "A done after retries", int'(a_done), 1);
      check("R6", "B done after retries", int'(b_done), 1);
      check("R8", "A retry still saturated", int'(a_retry), 3);
      check("R5", "A alignment pulses seen", (a_pulses >= 1) ? 1 : 0, 1);
      check("R5", "B alignment pulses seen", b_pulses, 0);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule